// File: doc/BRIEF.md
# Pin Edge Script Dispatcher

This block turns edges on six general-purpose input pins into requests to run stored scripts. Each pin is synchronised and debounced. Enabled edges are then qualified against two mask registers. The first mask arms falling edges on a pin, and the second adds rising edges for pins that are already armed. When a qualified edge is seen, the block issues a start request carrying the 8-bit script index held in that pin's jump register. Scripts can rewrite the jump registers at run time, so one button can step through a series of actions.

A trigger that arrives while a script is running aborts that script first, and the replacement starts one cycle later. A trigger that arrives while the device is powered down first starts the reserved wake-up script, index 2. The pin's own script starts once the wake-up script has run and finished. While the serial-interface select is active (low), the three lowest pins carry serial traffic and cannot trigger. Jump registers and masks are ordinary registers. Power-down does not clear them, so a configuration survives sleep.

Top module: `edge_script_launcher`

## Requirements
- R1: After reset, start_o, abort_o and wake_o are 0, all jump registers are 0x00 and both masks are 0x00, so no pin edge produces a start.
- R2: Each pin passes through a two-flop synchroniser and a debouncer that needs 4 consecutive samples at the new level. A pin change set up before clock edge k gives a start_o pulse in the cycle after edge k+6. A change lasting 3 cycles or fewer produces nothing.
- R3: A trigger on pin n starts with start_idx_o equal to jump register Rn. Config writes use address 0..6 for R0..R6, 8 for the falling mask and 9 for the rising-add mask, and any other address is ignored.
- R4: Bit n of the falling mask (address 8) arms falling edges on pin n. Bit n of the rising-add mask (address 9) also arms rising edges on pin n, but only while falling-mask bit n is 1.
- R5: With the falling mask at 0x00, no edge on any pin triggers, whatever the rising-add mask holds.
- R6: When several pins qualify in the same cycle, only the lowest-numbered pin is served and the others are dropped.
- R7: On a trigger while script_busy_i is 1 and pwr_down_i is 0, abort_o pulses for one cycle and start_o with the pin's index follows in the next cycle.
- R8: On a trigger while pwr_down_i is 1, start_o pulses with index 2 and wake_o high. The pin's own script then starts one cycle after script_busy_i, having risen, falls again.
- R9: While spi_sel_n_i is 0, pins 0, 1 and 2 produce no trigger, and pins 3 to 5 still do.
- R10: Jump registers and masks keep their values while pwr_down_i is 1 and change only on config writes.
- R11: abort_o and start_o are never high in the same cycle, and wake_o is high only together with a start of index 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Raw trigger pins, idle high |
| spi_sel_n_i | input | 1 | Serial select, active low; blocks pins 0..2 |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 4 | Config address (0..6 jump, 8 falling mask, 9 rising-add mask) |
| cfg_wdata_i | input | 8 | Config write data |
| pwr_down_i | input | 1 | Device is in power-down |
| script_busy_i | input | 1 | A script is currently executing |
| start_o | output | 1 | One-cycle script start request |
| start_idx_o | output | 8 | Index of the script to start, valid with start_o |
| abort_o | output | 1 | One-cycle abort of the running script |
| wake_o | output | 1 | Marks a start of the wake-up script |

## Verification
A pin change driven just after a falling clock edge reaches start_o after seven rising edges. These are two synchroniser flops, four debounce samples with a registered edge flag, and the output register. The bench therefore checks that start_o is still 0 at the sixth edge and carries the pulse at the seventh. When the start follows an abort, the start comes one cycle after the abort pulse. When the start follows a wake-up, it comes one edge after script_busy_i falls, and the bench samples at the falling edge in between. Glitch and lost-priority cases are checked by counting start pulses over a window longer than the full latency.

// File: rtl/edge_launch_pkg.sv
package edge_launch_pkg;

  localparam int MAX_PINS  = 8;
  localparam int PIN_SEL_W = 3;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_GAP,
    DS_WAKE_HI,
    DS_WAKE_LO
  } disp_state_t;

  // lowest set bit of a padded hit vector
  function automatic logic [PIN_SEL_W-1:0] lowest_hit(input logic [MAX_PINS-1:0] v);
    logic [PIN_SEL_W-1:0] r;
    r = '0;
    for (int i = MAX_PINS - 1; i >= 0; i--) begin
      if (v[i]) r = PIN_SEL_W'(i);
    end
    return r;
  endfunction

  // does an edge of this polarity qualify under the two mask bits
  function automatic logic edge_armed(input logic fall_bit, input logic both_bit,
                                      input logic is_rise);
    return fall_bit & (~is_rise | both_bit);
  endfunction

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
  parameter int   SYNC_STAGES = 2,
  parameter int   DEB_CNT     = 4,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int CNT_W = $clog2(DEB_CNT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sampled;
  logic                   stable_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   settle_now;
  logic                   fall_q, rise_q;

  assign sampled    = sync_q[SYNC_STAGES-1];
  assign settle_now = (sampled != stable_q) && (cnt_q == CNT_W'(DEB_CNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= IDLE_LEVEL;
      cnt_q    <= '0;
      fall_q   <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      fall_q <= settle_now & ~sampled;
      rise_q <= settle_now & sampled;
      if (sampled == stable_q) begin
        cnt_q <= '0;
      end else if (settle_now) begin
        stable_q <= sampled;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;
  assign rise_o = rise_q;

  // R2: a new debounced level must have been seen on the last two samples
  p_settle_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stable_q) |-> ($past(sampled) == stable_q && $past(sampled, 2) == stable_q));

  // R2: an edge flag follows a change of the debounced level
  p_edge_marks_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_q || rise_q) |-> (stable_q == rise_q));

endmodule

// File: rtl/trigger_config_bank.sv
module trigger_config_bank #(
  parameter int NUM_JUMP  = 7,
  parameter int NUM_PINS  = 6,
  parameter int IDX_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int FALL_ADDR = 8,
  parameter int BOTH_ADDR = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [IDX_W-1:0]    wdata_i,
  output logic [IDX_W-1:0]    jump_o [NUM_JUMP],
  output logic [NUM_PINS-1:0] fall_mask_o,
  output logic [NUM_PINS-1:0] both_mask_o
);
  logic [NUM_PINS-1:0] fall_q, both_q;
  logic                hit_fall, hit_both;

  assign hit_fall = we_i && (addr_i == ADDR_W'(FALL_ADDR));
  assign hit_both = we_i && (addr_i == ADDR_W'(BOTH_ADDR));

  for (genvar g = 0; g < NUM_JUMP; g++) begin : g_jump
    logic [IDX_W-1:0] jq;
    logic             hit;
    assign hit = we_i && (addr_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   jq <= '0;
      else if (hit) jq <= wdata_i;
    end
    assign jump_o[g] = jq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
      both_q <= '0;
    end else begin
      if (hit_fall) fall_q <= wdata_i[NUM_PINS-1:0];
      if (hit_both) both_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  assign fall_mask_o = fall_q;
  assign both_mask_o = both_q;

  // R10: masks only move on a config write
  p_masks_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(fall_q) && $stable(both_q)));

  // R3: jump register 0 only moves on a write to its own address
  p_jump0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == '0) |=> $stable(jump_o[0]));

endmodule

// File: rtl/trigger_qualifier.sv
module trigger_qualifier
  import edge_launch_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SPI_PINS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  fall_ev_i,
  input  logic [NUM_PINS-1:0]  rise_ev_i,
  input  logic [NUM_PINS-1:0]  fall_mask_i,
  input  logic [NUM_PINS-1:0]  both_mask_i,
  input  logic                 spi_sel_n_i,
  output logic                 trig_v_o,
  output logic [PIN_SEL_W-1:0] trig_pin_o
);
  logic [NUM_PINS-1:0] hit;
  logic [MAX_PINS-1:0] hit_pad;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic armed, blocked;
    assign armed = (fall_ev_i[g] & edge_armed(fall_mask_i[g], both_mask_i[g], 1'b0)) |
                   (rise_ev_i[g] & edge_armed(fall_mask_i[g], both_mask_i[g], 1'b1));
    if (g < SPI_PINS) begin : g_shared
      assign blocked = ~spi_sel_n_i;
    end else begin : g_free
      assign blocked = 1'b0;
    end
    assign hit[g] = armed & ~blocked;
  end

  always_comb begin
    hit_pad                = '0;
    hit_pad[NUM_PINS-1:0]  = hit;
  end

  assign trig_v_o   = |hit;
  assign trig_pin_o = lowest_hit(hit_pad);

  // R9: shared pins never win while the serial select is active
  p_spi_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sel_n_i && trig_v_o) |-> (int'(trig_pin_o) >= SPI_PINS));

  // R5: an empty falling mask blocks every trigger
  p_fall_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_mask_i == '0) |-> !trig_v_o);

  // R6: the served pin really had an edge
  p_served_has_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_v_o |-> (fall_ev_i[trig_pin_o] || rise_ev_i[trig_pin_o]));

endmodule

// File: rtl/script_dispatch.sv
module script_dispatch
  import edge_launch_pkg::*;
#(
  parameter int               NUM_JUMP = 7,
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] WAKE_IDX = 8'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_v_i,
  input  logic [PIN_SEL_W-1:0] trig_pin_i,
  input  logic [IDX_W-1:0]     jump_i [NUM_JUMP],
  input  logic                 pwr_down_i,
  input  logic                 busy_i,
  output logic                 start_o,
  output logic [IDX_W-1:0]     start_idx_o,
  output logic                 abort_o,
  output logic                 wake_o
);
  disp_state_t          state_q;
  logic [PIN_SEL_W-1:0] pend_pin_q;
  logic                 start_q, abort_q, wake_q;
  logic [IDX_W-1:0]     idx_q;

  logic trig_wake, trig_abort, trig_direct, gap_fire, chain_fire;

  assign trig_wake   = trig_v_i && pwr_down_i;
  assign trig_abort  = trig_v_i && !pwr_down_i && busy_i;
  assign trig_direct = trig_v_i && !pwr_down_i && !busy_i;
  assign gap_fire    = !trig_v_i && (state_q == DS_GAP);
  assign chain_fire  = !trig_v_i && (state_q == DS_WAKE_LO) && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= DS_IDLE;
      pend_pin_q <= '0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      wake_q     <= 1'b0;
      idx_q      <= '0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      wake_q  <= 1'b0;
      if (trig_v_i) begin
        pend_pin_q <= trig_pin_i;
        if (trig_wake) begin
          start_q <= 1'b1;
          wake_q  <= 1'b1;
          idx_q   <= WAKE_IDX;
          state_q <= DS_WAKE_HI;
        end else if (trig_abort) begin
          abort_q <= 1'b1;
          state_q <= DS_GAP;
        end else begin
          start_q <= 1'b1;
          idx_q   <= jump_i[trig_pin_i];
          state_q <= DS_IDLE;
        end
      end else begin
        case (state_q)
          DS_GAP: begin
            start_q <= 1'b1;
            idx_q   <= jump_i[pend_pin_q];
            state_q <= DS_IDLE;
          end
          DS_WAKE_HI: if (busy_i) state_q <= DS_WAKE_LO;
          DS_WAKE_LO: if (chain_fire) begin
            start_q <= 1'b1;
            idx_q   <= jump_i[pend_pin_q];
            state_q <= DS_IDLE;
          end
          default: state_q <= DS_IDLE;
        endcase
      end
    end
  end

  assign start_o     = start_q;
  assign start_idx_o = idx_q;
  assign abort_o     = abort_q;
  assign wake_o      = wake_q;

  // R11: stop and start never share a cycle
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && start_o));

  // R8 / R11: wake marks only a start of the reserved index
  p_wake_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (start_o && start_idx_o == WAKE_IDX));

  // R7: an abort is followed by a start unless a fresh abort pre-empts it
  p_abort_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (start_o || abort_o));

  // R7: a trigger into a busy, powered device yields an abort
  p_busy_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_abort |=> abort_o);

  // R8: a powered-down trigger yields a wake start next cycle
  p_down_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wake |=> wake_o);

endmodule

// File: rtl/edge_script_launcher.sv
module edge_script_launcher
  import edge_launch_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int NUM_JUMP    = 7,
  parameter int IDX_W       = 8,
  parameter int ADDR_W      = 4,
  parameter int SPI_PINS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CNT     = 4,
  parameter int WAKE_INDEX  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                spi_sel_n_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [IDX_W-1:0]    cfg_wdata_i,
  input  logic                pwr_down_i,
  input  logic                script_busy_i,
  output logic                start_o,
  output logic [IDX_W-1:0]    start_idx_o,
  output logic                abort_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0]  fall_ev, rise_ev;
  logic [IDX_W-1:0]     jump [NUM_JUMP];
  logic [NUM_PINS-1:0]  fall_mask, both_mask;
  logic                 trig_v;
  logic [PIN_SEL_W-1:0] trig_pin;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cond
    pin_conditioner #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CNT    (DEB_CNT),
      .IDLE_LEVEL (1'b1)
    ) i_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i[g]),
      .fall_o(fall_ev[g]),
      .rise_o(rise_ev[g])
    );
  end

  trigger_config_bank #(
    .NUM_JUMP(NUM_JUMP),
    .NUM_PINS(NUM_PINS),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
  ) i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .jump_o     (jump),
    .fall_mask_o(fall_mask),
    .both_mask_o(both_mask)
  );

  trigger_qualifier #(
    .NUM_PINS(NUM_PINS),
    .SPI_PINS(SPI_PINS)
  ) i_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_ev_i  (fall_ev),
    .rise_ev_i  (rise_ev),
    .fall_mask_i(fall_mask),
    .both_mask_i(both_mask),
    .spi_sel_n_i(spi_sel_n_i),
    .trig_v_o   (trig_v),
    .trig_pin_o (trig_pin)
  );

  script_dispatch #(
    .NUM_JUMP(NUM_JUMP),
    .IDX_W   (IDX_W),
    .WAKE_IDX(IDX_W'(WAKE_INDEX))
  ) i_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_v_i   (trig_v),
    .trig_pin_i (trig_pin),
    .jump_i     (jump),
    .pwr_down_i (pwr_down_i),
    .busy_i     (script_busy_i),
    .start_o    (start_o),
    .start_idx_o(start_idx_o),
    .abort_o    (abort_o),
    .wake_o     (wake_o)
  );

  // R1: nothing leaves the block without a served trigger path
  p_quiet_without_trig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_mask == '0 && !$past(trig_v) && !$past(script_busy_i) && !$past(pwr_down_i))
      |-> !abort_o);

endmodule

// File: tb/test_edge_script_launcher.sv
module test_edge_script_launcher;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pins = 6'h3F;
  logic       spi_sel_n = 1'b1;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       pdown = 1'b0;
  logic       busy = 1'b0;
  logic       start, abort, wake;
  logic [7:0] sidx;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  edge_script_launcher i_edge_script_launcher (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pins),
    .spi_sel_n_i  (spi_sel_n),
    .cfg_we_i     (we),
    .cfg_addr_i   (addr),
    .cfg_wdata_i  (wdata),
    .pwr_down_i   (pdown),
    .script_busy_i(busy),
    .start_o      (start),
    .start_idx_o  (sidx),
    .abort_o      (abort),
    .wake_o       (wake)
  );

  typedef struct packed {
    logic [2:0] pin;
    logic       lvl;
    logic [7:0] fmask;
    logic [7:0] bmask;
    logic       fire;
  } vec_t;

  // pin, new level, falling mask, rising-add mask, expect a start
  localparam vec_t VECS [12] = '{
    '{3'd0, 1'b0, 8'h3F, 8'h00, 1'b1},
    '{3'd0, 1'b1, 8'h3F, 8'h00, 1'b0},
    '{3'd4, 1'b0, 8'hFF, 8'h10, 1'b1},
    '{3'd4, 1'b1, 8'hFF, 8'h10, 1'b1},
    '{3'd5, 1'b0, 8'h00, 8'h3F, 1'b0},
    '{3'd5, 1'b1, 8'h00, 8'h3F, 1'b0},
    '{3'd3, 1'b0, 8'h08, 8'h00, 1'b1},
    '{3'd2, 1'b0, 8'h08, 8'h00, 1'b0},
    '{3'd2, 1'b1, 8'h04, 8'h04, 1'b1},
    '{3'd1, 1'b0, 8'h02, 8'h02, 1'b1},
    '{3'd1, 1'b1, 8'h02, 8'h00, 1'b0},
    '{3'd3, 1'b1, 8'h08, 8'h08, 1'b1}
  };

  function automatic logic [7:0] jump_val(input int n);
    return 8'(8'h11 * (n + 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // drive a pin, check no early start, then check the due cycle
  task automatic drive_check(input int p, input logic lvl, input logic fire,
                             input logic [7:0] exp_idx, input string req);
    @(negedge clk);
    pins[p] = lvl;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk({req, " not early"}, {31'd0, start}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " start"}, {31'd0, start}, {31'd0, fire});
    if (fire) chk({req, " index"}, {24'd0, sidx}, {24'd0, exp_idx});
    repeat (8) @(negedge clk);
  endtask

  task automatic count_starts(input int cycles, output int n, output logic [7:0] last);
    n = 0; last = '0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (start) begin n++; last = sidx; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 start after reset", {31'd0, start}, 32'd0);
    chk("R1 abort after reset", {31'd0, abort}, 32'd0);
    chk("R1 wake after reset",  {31'd0, wake},  32'd0);
    // R1 / R5: masks clear after reset, edge ignored
    @(negedge clk); pins[2] = 1'b0;
    count_starts(14, n, last);
    chk("R1 no trigger with cleared masks", n, 0);
    @(negedge clk); pins[2] = 1'b1;
    repeat (10) @(negedge clk);

    for (int j = 0; j < 7; j++) cfg_write(4'(j), jump_val(j));
    // R3: writes to unmapped addresses are ignored
    cfg_write(4'd7, 8'hEE);
    cfg_write(4'd15, 8'hEE);

    // table walk: R3 / R4 / R5
    for (int v = 0; v < 12; v++) begin
      cfg_write(4'd8, VECS[v].fmask);
      cfg_write(4'd9, VECS[v].bmask);
      drive_check(int'(VECS[v].pin), VECS[v].lvl, VECS[v].fire,
                  jump_val(int'(VECS[v].pin)), $sformatf("R4 vec%0d", v));
    end

    // R2: a 3-cycle glitch is filtered, a 4-cycle pulse is accepted
    cfg_write(4'd8, 8'h3F);
    cfg_write(4'd9, 8'h00);
    @(negedge clk); pins[0] = 1'b0;
    repeat (3) @(negedge clk);
    pins[0] = 1'b1;
    count_starts(14, n, last);
    chk("R2 short glitch ignored", n, 0);
    @(negedge clk); pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    pins[0] = 1'b1;
    count_starts(14, n, last);
    chk("R2 four-sample pulse accepted", n, 1);
    chk("R3 pulse index R0", last, jump_val(0));

    // R6: two pins at once, lowest wins, other dropped
    @(negedge clk); pins[1] = 1'b0; pins[3] = 1'b0;
    count_starts(14, n, last);
    chk("R6 single start", n, 1);
    chk("R6 lowest pin index", last, jump_val(1));
    @(negedge clk); pins[1] = 1'b1; pins[3] = 1'b1;
    repeat (12) @(negedge clk);

    // R9: serial select blocks pins 0..2 only
    spi_sel_n = 1'b0;
    drive_check(0, 1'b0, 1'b0, 8'h00, "R9 pin0 blocked");
    drive_check(3, 1'b0, 1'b1, jump_val(3), "R9 pin3 passes");
    @(negedge clk); pins[0] = 1'b1; pins[3] = 1'b1;
    repeat (12) @(negedge clk);
    spi_sel_n = 1'b1;

    // R7: trigger while busy aborts first
    busy = 1'b1;
    @(negedge clk); pins[5] = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R7 abort pulse", {31'd0, abort}, 32'd1);
    chk("R11 no start with abort", {31'd0, start}, 32'd0);
    @(negedge clk);
    chk("R7 start after abort", {31'd0, start}, 32'd1);
    chk("R7 index after abort", sidx, jump_val(5));
    chk("R7 abort is one cycle", {31'd0, abort}, 32'd0);
    busy = 1'b0;
    @(negedge clk); pins[5] = 1'b1;
    repeat (12) @(negedge clk);

    // R8 / R10: wake-up then chained pin script, config kept in power-down
    cfg_write(4'd4, 8'h5A);
    pdown = 1'b1;
    repeat (5) @(negedge clk);
    @(negedge clk); pins[4] = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R8 wake start", {31'd0, start}, 32'd1);
    chk("R8 wake index", sidx, 8'd2);
    chk("R8 wake flag", {31'd0, wake}, 32'd1);
    busy = 1'b1;
    @(negedge clk);
    pdown = 1'b0;
    count_starts(4, n, last);
    chk("R8 pin script held while wake runs", n, 0);
    busy = 1'b0;
    @(negedge clk);
    chk("R10 chained start", {31'd0, start}, 32'd1);
    chk("R10 index kept through power-down", sidx, 8'h5A);
    chk("R8 wake low on chained start", {31'd0, wake}, 32'd0);
    @(negedge clk); pins[4] = 1'b1;
    repeat (12) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule